// File: doc/BRIEF.md
# Zero-Cross Deferred Settings Commit

This block sits between a serial control receiver and the active settings registers of an audio volume and tone path. Each time the receiver delivers a complete 44-bit control word, the block decides when that word becomes the applied setting. In deferred mode it parks the word and waits for a zero-crossing pulse from one of four detection points (input selector, volume, tone or fader) so the analog switches change at a quiet instant. If no crossing arrives before a programmable timeout, the word is applied anyway. In immediate mode the word is applied on the next clock edge.

The mode and detection-point fields are taken from the same word being deferred. They therefore govern that word's own commit, and a single transfer both sets the policy and carries the new settings. The analog comparators and the RC timer are outside the block. The timer is modelled as a count of `tmo_tick` pulses that ends at a parameter value.

Top module: `zc_commit_ctrl`

## Requirements
- R1: During and after a synchronous active-high reset, `applied_word` is all zeros, `commit_pulse` is low and `holding` is low.
- R2: An accepted word with bits [37:36] equal to 2'b00 is held. In the cycle after the strobe, `holding` is high, `commit_pulse` is low and `applied_word` is unchanged.
- R3: An accepted word with bits [37:36] equal to any value other than 2'b00 is applied in the cycle after the strobe. `commit_pulse` is high, `applied_word` equals the word and `holding` is low.
- R4: Bits [39:38] of the held word pick the detection point: 00 selector (`zc_hit[0]`), 01 volume (`zc_hit[1]`), 10 tone (`zc_hit[2]`) and 11 fader (`zc_hit[3]`). A pulse on the picked input while holding applies the held word in the following cycle.
- R5: While holding, pulses on inputs that are not picked do not commit the word. Bits [41:40] have no effect on which input is picked.
- R6: While holding with no picked pulse, the held word is applied on the TMO_TICKS-th `tmo_tick` after the strobe. The commit appears in the cycle after that tick.
- R7: A new strobe while a word is held replaces the held word, takes that word's mode and point, and restarts the tick count from zero.
- R8: `commit_pulse` is high for exactly one cycle per commit, and `holding` is low in that cycle. `applied_word` changes only in a cycle where `commit_pulse` is high.
- R9: A zero-crossing pulse or tick in the same cycle as a strobe has no effect. The new word is accepted as if that pulse or tick were absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | One-cycle strobe: a new control word is present |
| word_in | input | WORD_W | New control word from the serial receiver |
| zc_hit | input | 4 | Zero-crossing pulses: [0] selector, [1] volume, [2] tone, [3] fader |
| tmo_tick | input | 1 | Timebase tick that advances the timeout count |
| applied_word | output | WORD_W | Currently applied control word (registered) |
| commit_pulse | output | 1 | One-cycle pulse in the cycle `applied_word` takes a new value |
| holding | output | 1 | A word is waiting for a zero crossing or the timeout |

## Verification
Every result of this block is due one clock edge after its cause. This holds for a strobe, a picked zero-crossing pulse and the final timeout tick. The bench drives inputs on the falling edge. It advances its requirement model on the rising edge and compares all three outputs on the next falling edge, so each check looks at exactly the cycle the cause sets. The timeout is measured by counting ticked cycles from the strobe until `commit_pulse` appears and comparing that count with TMO_TICKS. The replacement case checks that no commit appears at the point where the first word would have timed out.

// File: rtl/zc_commit_pkg.sv
package zc_commit_pkg;
  localparam int MODE_LSB  = 36;  // two mode bits, 2'b00 = defer to a zero crossing
  localparam int POINT_LSB = 38;  // two point bits decoded, two above them unused
  localparam int ZC_POINTS = 4;
  localparam int PT_W      = 2;

  typedef enum logic [PT_W-1:0] {
    PT_SELECTOR = 2'd0,
    PT_VOLUME   = 2'd1,
    PT_TONE     = 2'd2,
    PT_FADER    = 2'd3
  } zc_point_e;

  function automatic logic wants_defer(input logic [1:0] mode);
    return mode == 2'b00;
  endfunction
endpackage

// File: rtl/zc_point_select.sv
module zc_point_select
  import zc_commit_pkg::*;
(
  input  logic [ZC_POINTS-1:0] pulses,
  input  logic [PT_W-1:0]      point,
  output logic                 hit
);
  logic [ZC_POINTS-1:0] match;

  for (genvar i = 0; i < ZC_POINTS; i++) begin : g_match
    assign match[i] = pulses[i] && (point == PT_W'(i));
  end

  assign hit = |match;
endmodule

// File: rtl/zc_timeout.sv
module zc_timeout #(
  parameter int TMO_TICKS = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  input  logic tick,
  output logic expire
);
  localparam int CNT_W = (TMO_TICKS > 1) ? $clog2(TMO_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire = run && tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (run && tick && !expire) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/zc_commit_ctrl.sv
module zc_commit_ctrl
  import zc_commit_pkg::*;
#(
  parameter int WORD_W    = 44,
  parameter int TMO_TICKS = 25
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 word_valid,
  input  logic [WORD_W-1:0]    word_in,
  input  logic [ZC_POINTS-1:0] zc_hit,
  input  logic                 tmo_tick,
  output logic [WORD_W-1:0]    applied_word,
  output logic                 commit_pulse,
  output logic                 holding
);
  logic [WORD_W-1:0] applied_q;
  logic [WORD_W-1:0] held_q;
  logic              commit_q;
  logic              hold_q;
  zc_point_e         point_q;

  logic defer_new;
  logic accept_defer;
  logic point_hit;
  logic expire;
  logic fire;

  assign defer_new    = wants_defer(word_in[MODE_LSB +: 2]);
  assign accept_defer = word_valid && defer_new;

  zc_point_select u_sel (
    .pulses (zc_hit),
    .point  (point_q),
    .hit    (point_hit)
  );

  zc_timeout #(.TMO_TICKS(TMO_TICKS)) u_tmo (
    .clk     (clk),
    .rst     (rst),
    .restart (accept_defer),
    .run     (hold_q),
    .tick    (tmo_tick),
    .expire  (expire)
  );

  assign fire = hold_q && !word_valid && (point_hit || expire);

  always_ff @(posedge clk) begin
    if (rst) begin
      applied_q <= '0;
      held_q    <= '0;
      commit_q  <= 1'b0;
      hold_q    <= 1'b0;
      point_q   <= PT_SELECTOR;
    end else begin
      commit_q <= 1'b0;
      if (word_valid) begin
        if (defer_new) begin
          held_q  <= word_in;
          point_q <= zc_point_e'(word_in[POINT_LSB +: PT_W]);
          hold_q  <= 1'b1;
        end else begin
          applied_q <= word_in;
          commit_q  <= 1'b1;
          hold_q    <= 1'b0;
        end
      end else if (fire) begin
        applied_q <= held_q;
        commit_q  <= 1'b1;
        hold_q    <= 1'b0;
      end
    end
  end

  assign applied_word = applied_q;
  assign commit_pulse = commit_q;
  assign holding      = hold_q;
endmodule

// File: rtl/zc_commit_checker.sv
module zc_commit_checker
  import zc_commit_pkg::*;
#(
  parameter int WORD_W = 44
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 word_valid,
  input logic [WORD_W-1:0]    word_in,
  input logic [ZC_POINTS-1:0] zc_hit,
  input logic                 tmo_tick,
  input logic [WORD_W-1:0]    applied_word,
  input logic                 commit_pulse,
  input logic                 holding
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (applied_word == '0) && !commit_pulse && !holding);  // R1

  AST_DEFER_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (word_valid && word_in[MODE_LSB +: 2] == 2'b00) |=> holding && !commit_pulse);  // R2

  AST_BYPASS_NOW: assert property (@(posedge clk) disable iff (rst)
    (word_valid && word_in[MODE_LSB +: 2] != 2'b00)
      |=> commit_pulse && !holding && (applied_word == $past(word_in)));  // R3

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
    (holding && !word_valid && zc_hit == '0 && !tmo_tick) |=> holding && !commit_pulse);  // R5

  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    commit_pulse |-> !holding);  // R8

  AST_IDLE_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (!holding && !word_valid) |=> !commit_pulse);  // R8

  AST_APPLIED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !commit_pulse |-> $stable(applied_word));  // R8
endmodule

bind zc_commit_ctrl zc_commit_checker #(.WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .word_valid   (word_valid),
  .word_in      (word_in),
  .zc_hit       (zc_hit),
  .tmo_tick     (tmo_tick),
  .applied_word (applied_word),
  .commit_pulse (commit_pulse),
  .holding      (holding)
);

// File: tb/tb_zc_commit_ctrl.sv
`timescale 1ns/1ps
module tb_zc_commit_ctrl;
  localparam int W   = 44;
  localparam int TMO = 25;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         word_valid = 1'b0;
  logic [W-1:0] word_in = '0;
  logic [3:0]   zc_hit = '0;
  logic         tmo_tick = 1'b0;
  logic [W-1:0] applied_word;
  logic         commit_pulse;
  logic         holding;

  always #10 clk = ~clk;  // 50 MHz

  zc_commit_ctrl #(.WORD_W(W), .TMO_TICKS(TMO)) dut (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_in(word_in),
    .zc_hit(zc_hit), .tmo_tick(tmo_tick), .applied_word(applied_word),
    .commit_pulse(commit_pulse), .holding(holding)
  );

  int checks = 0;
  int errors = 0;

  // requirement model
  logic [W-1:0] m_applied = '0, m_word = '0;
  logic         m_pulse = 1'b0, m_hold = 1'b0;
  logic [1:0]   m_pt = '0;
  int           m_cnt = 0;

  function automatic logic [W-1:0] mk(input logic [1:0] mode, input logic [1:0] pt);
    logic [W-1:0] w;
    w = {$urandom, $urandom};
    w[37:36] = mode;
    w[39:38] = pt;
    return w;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_step();
    logic fire;
    m_pulse = 1'b0;
    if (rst) begin
      m_applied = '0; m_hold = 1'b0; m_pt = '0; m_cnt = 0; m_word = '0;
    end else if (word_valid) begin
      if (word_in[37:36] == 2'b00) begin
        m_word = word_in; m_pt = word_in[39:38]; m_hold = 1'b1; m_cnt = 0;
      end else begin
        m_applied = word_in; m_pulse = 1'b1; m_hold = 1'b0;
      end
    end else if (m_hold) begin
      fire = zc_hit[m_pt];
      if (tmo_tick) begin
        if (m_cnt == TMO - 1) fire = 1'b1;
        else m_cnt++;
      end
      if (fire) begin
        m_applied = m_word; m_pulse = 1'b1; m_hold = 1'b0;
      end
    end
  endtask

  // one clock: inputs already set, model follows the edge, compare on the falling edge
  task automatic cyc(input logic wv, input logic [W-1:0] w, input logic [3:0] zc, input logic tk);
    word_valid = wv; word_in = w; zc_hit = zc; tmo_tick = tk;
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R8 model applied_word", applied_word, m_applied);
    chk("R8 model commit_pulse", W'(commit_pulse), W'(m_pulse));
    chk("R8 model holding", W'(holding), W'(m_hold));
    word_valid = 1'b0; zc_hit = '0; tmo_tick = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : stim
    logic [W-1:0] a, b;
    int n;
    void'($urandom(32'd2718));
    @(negedge clk);
    cyc(1'b0, '0, '0, 1'b0);
    cyc(1'b0, '0, '0, 1'b0);
    chk("R1 reset applied", applied_word, '0);
    chk("R1 reset pulse", W'(commit_pulse), '0);
    chk("R1 reset holding", W'(holding), '0);
    rst = 1'b0;
    cyc(1'b0, '0, '0, 1'b1);

    // R3: bypass modes 11 and 01
    a = mk(2'b11, 2'b01);
    cyc(1'b1, a, 4'hF, 1'b1);
    chk("R3 bypass applied", applied_word, a);
    chk("R3 bypass pulse", W'(commit_pulse), W'(1));
    cyc(1'b0, '0, '0, 1'b0);
    chk("R8 single pulse", W'(commit_pulse), '0);
    a = mk(2'b01, 2'b00);
    cyc(1'b1, a, '0, 1'b0);
    chk("R3 mode 01 bypass", applied_word, a);

    // R2/R4/R5: defer each point, with bits 41:40 randomized
    for (int p = 0; p < 4; p++) begin
      b = applied_word;
      a = mk(2'b00, 2'(p));
      a[41:40] = 2'($urandom);
      cyc(1'b1, a, '0, 1'b0);
      chk("R2 defer holding", W'(holding), W'(1));
      chk("R2 defer no pulse", W'(commit_pulse), '0);
      chk("R2 defer applied unchanged", applied_word, b);
      for (int q = 0; q < 4; q++) begin
        if (q != p) begin
          cyc(1'b0, '0, 4'(1 << q), 1'b0);
          chk("R5 unselected ignored", W'(holding), W'(1));
          chk("R5 unselected applied", applied_word, b);
        end
      end
      cyc(1'b0, '0, 4'(1 << p), 1'b0);
      chk("R4 selected commit", applied_word, a);
      chk("R4 selected pulse", W'(commit_pulse), W'(1));
      chk("R8 holding clears", W'(holding), '0);
    end

    // R6: timeout with a tick every cycle
    a = mk(2'b00, 2'b10);
    cyc(1'b1, a, '0, 1'b0);
    n = 0;
    while (!commit_pulse && n < 100) begin
      cyc(1'b0, '0, 4'b1011, 1'b1);
      n++;
    end
    chk("R6 timeout tick count", W'(n), W'(TMO));
    chk("R6 timeout applied", applied_word, a);

    // R7: replacement restarts the count
    a = mk(2'b00, 2'b11);
    b = mk(2'b00, 2'b11);
    cyc(1'b1, a, '0, 1'b0);
    for (int i = 0; i < 20; i++) cyc(1'b0, '0, '0, 1'b1);
    cyc(1'b1, b, '0, 1'b1);
    for (int i = 0; i < TMO - 1; i++) cyc(1'b0, '0, '0, 1'b1);
    chk("R7 no early timeout", W'(holding), W'(1));
    cyc(1'b0, '0, '0, 1'b1);
    chk("R7 replaced word applied", applied_word, b);

    // R9: pulse and tick together with a new strobe
    a = mk(2'b00, 2'b00);
    cyc(1'b1, a, '0, 1'b0);
    b = mk(2'b00, 2'b00);
    cyc(1'b1, b, 4'hF, 1'b1);
    chk("R9 same-cycle pulse ignored", W'(commit_pulse), '0);
    chk("R9 still holding", W'(holding), W'(1));
    cyc(1'b0, '0, 4'b0001, 1'b0);
    chk("R9 later pulse commits new word", applied_word, b);

    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      logic wv;
      wv = ($urandom_range(0, 15) == 0);
      cyc(wv, mk(($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b00, 2'($urandom)),
          ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0,
          ($urandom_range(0, 1) == 0));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule